// File: doc/BRIEF.md
# Modulated Fractional Baud Generator

This block produces the bit timing of a serial character frame from one clock. The ratio of clock to baud rate is seldom a whole number. The block therefore times each bit for an integer divisor plus one extra cycle chosen by an 8-bit modulation pattern, so that over a frame the mean period tracks the true fractional ratio. The pattern is read from its lowest bit upward, one bit per bit period. It wraps to its lowest bit after eight periods and starts again at that lowest bit on every frame.

A one-cycle `start` pulse begins a frame. The block then emits a one-cycle boundary strobe at the end of every bit period and a mid-bit sample strobe inside each period. It also reports the index of the bit being timed. After the last bit of the frame the generator falls idle until the next start. A shifter, a parity unit or a receiver's start detector sits beside it and consumes the strobes.

Top module: `baud_mod_gen`

## Requirements
- R1: Bit k of a frame lasts exactly `divisor + m` clock cycles, where m is the modulation bit chosen for it. Its end is marked by `bit_tick` high for one cycle.
- R2: The pattern is consumed from bit 0 (least significant) upward. Pattern bit 0 selects the length of bit index 0, the start bit.
- R3: Bit index k uses pattern bit (k mod 8), so the ninth bit period of a frame uses pattern bit 0 again.
- R4: When `start` is sampled high at edge E0, the N-th `bit_tick` of the frame is high in the cycle that follows edge E0 + N·divisor + (sum of the pattern bits used by bits 0..N-1). For divisor 13 and pattern 0x6B, the twelfth tick follows edge E0+164.
- R5: `sample_tick` is high for one cycle following edge S + floor(L/2). Here S is the edge at which a bit begins (E0 or its preceding boundary edge) and L is that bit's length. It never coincides with `bit_tick`.
- R6: `bit_idx` equals j after the edge at which bit j begins, and returns to 0 after the frame's final boundary. It is 0 while idle.
- R7: A frame has FRAME_BITS bit periods (default 12). After the last boundary no strobe occurs until the next accepted start.
- R8: A `start` sampled during a running frame abandons it and begins a new frame at bit 0 with the pattern pointer back at bit 0. No strobe is produced for that edge.
- R9: While `divisor` is below 3, a start is ignored. A running frame is abandoned at the next edge, both strobes stay low and `bit_idx` is 0.
- R10: After reset, both strobes are low and `bit_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| divisor | input | 16 | Integer part of the division ratio (legal when 3 or more) |
| mod_pattern | input | 8 | Modulation pattern, one extra cycle per set bit |
| start | input | 1 | Begins a new frame when sampled high |
| bit_tick | output | 1 | One-cycle strobe at each bit-period boundary |
| sample_tick | output | 1 | One-cycle strobe at the middle of each bit |
| bit_idx | output | 4 | Index of the bit being timed |

## Verification
A wrong period counter or a modulation pointer that steps on the wrong edge moves a boundary strobe by at least one cycle. The cycle-by-cycle comparison of `bit_tick` then flags it within the same bit period, before the frame's cumulative count can disagree. A pointer that carries over between frames shows on the first bit of the following frame whenever the pattern is not uniform. A stale length held for the mid-bit point shifts `sample_tick` in the bit after the first odd/even length change. Random divisor and pattern pairs, with the 0x00 and 0xFF extremes and the smallest legal divisor, make each of these faults appear within a few frames.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int DEF_DIV_W      = 16;
    localparam int DEF_MOD_W      = 8;
    localparam int DEF_FRAME_BITS = 12;
    localparam int DEF_MIN_DIV    = 3;

    typedef enum logic {
        GEN_IDLE = 1'b0,
        GEN_RUN  = 1'b1
    } gen_mode_e;
endpackage

// File: rtl/baud_mod_pick.sv
module baud_mod_pick #(
    parameter int MOD_W = baud_pkg::DEF_MOD_W,
    localparam int PTR_W = (MOD_W > 1) ? $clog2(MOD_W) : 1
) (
    input  logic [MOD_W-1:0] pattern,
    input  logic [PTR_W-1:0] ptr,
    output logic             mod_bit
);
    always_comb begin
        mod_bit = 1'b0;
        for (int i = 0; i < MOD_W; i++) begin
            if (ptr == PTR_W'(i)) mod_bit = pattern[i];
        end
    end
endmodule

// File: rtl/baud_period_calc.sv
module baud_period_calc #(
    parameter int DIV_W   = baud_pkg::DEF_DIV_W,
    parameter int MIN_DIV = baud_pkg::DEF_MIN_DIV,
    localparam int LEN_W  = DIV_W + 1
) (
    input  logic [DIV_W-1:0] divisor,
    input  logic             mod_bit,
    output logic             div_ok,
    output logic [LEN_W-1:0] load_cnt,
    output logic [LEN_W-1:0] mid_cnt
);
    logic [LEN_W-1:0] len;

    always_comb begin
        div_ok   = ({1'b0, divisor} >= LEN_W'(MIN_DIV));
        len      = {1'b0, divisor} + LEN_W'(mod_bit);
        load_cnt = len - LEN_W'(1);
        mid_cnt  = len - (len >> 1);
    end

    // R1: reload value stays within one cycle of the divisor
    always_comb begin
        if (div_ok) begin
            p_len_bound_r1: assert ((load_cnt + LEN_W'(1) - {1'b0, divisor}) <= LEN_W'(1));
            p_mid_nonzero_r5: assert (mid_cnt != '0);
        end
    end
endmodule

// File: rtl/baud_mod_gen.sv
module baud_mod_gen #(
    parameter int DIV_W      = baud_pkg::DEF_DIV_W,
    parameter int MOD_W      = baud_pkg::DEF_MOD_W,
    parameter int FRAME_BITS = baud_pkg::DEF_FRAME_BITS,
    parameter int MIN_DIV    = baud_pkg::DEF_MIN_DIV,
    localparam int LEN_W     = DIV_W + 1,
    localparam int PTR_W     = (MOD_W > 1) ? $clog2(MOD_W) : 1,
    localparam int IDX_W     = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic [MOD_W-1:0] mod_pattern,
    input  logic             start,
    output logic             bit_tick,
    output logic             sample_tick,
    output logic [IDX_W-1:0] bit_idx
);
    import baud_pkg::*;

    typedef struct packed {
        gen_mode_e        mode;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] mid;
        logic [IDX_W-1:0] idx;
        logic [PTR_W-1:0] ptr;
        logic             tick;
        logic             samp;
    } gen_state_t;

    gen_state_t st_d, st_q;

    logic [PTR_W-1:0] ptr_inc;
    logic [PTR_W-1:0] ptr_sel;
    logic             mod_bit;
    logic             div_ok;
    logic [LEN_W-1:0] load_cnt;
    logic [LEN_W-1:0] mid_cnt;

    assign ptr_inc = (st_q.ptr == PTR_W'(MOD_W - 1)) ? '0 : st_q.ptr + PTR_W'(1);
    assign ptr_sel = start ? '0 : ptr_inc;

    baud_mod_pick #(.MOD_W(MOD_W)) u_pick (
        .pattern (mod_pattern),
        .ptr     (ptr_sel),
        .mod_bit (mod_bit)
    );

    baud_period_calc #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_calc (
        .divisor  (divisor),
        .mod_bit  (mod_bit),
        .div_ok   (div_ok),
        .load_cnt (load_cnt),
        .mid_cnt  (mid_cnt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        st_d.samp = 1'b0;
        if (!div_ok) begin
            st_d.mode = GEN_IDLE;
            st_d.cnt  = '0;
            st_d.idx  = '0;
            st_d.ptr  = '0;
        end else if (start) begin
            st_d.mode = GEN_RUN;
            st_d.cnt  = load_cnt;
            st_d.mid  = mid_cnt;
            st_d.idx  = '0;
            st_d.ptr  = '0;
        end else if (st_q.mode == GEN_RUN) begin
            if (st_q.cnt == '0) begin
                st_d.tick = 1'b1;
                if (st_q.idx == IDX_W'(FRAME_BITS - 1)) begin
                    st_d.mode = GEN_IDLE;
                    st_d.idx  = '0;
                    st_d.ptr  = '0;
                end else begin
                    st_d.idx = st_q.idx + IDX_W'(1);
                    st_d.ptr = ptr_inc;
                    st_d.cnt = load_cnt;
                    st_d.mid = mid_cnt;
                end
            end else begin
                st_d.cnt  = st_q.cnt - LEN_W'(1);
                st_d.samp = (st_q.cnt == st_q.mid);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: GEN_IDLE, cnt: '0, mid: '0, idx: '0, ptr: '0, tick: 1'b0, samp: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_tick    = st_q.tick;
    assign sample_tick = st_q.samp;
    assign bit_idx     = st_q.idx;

    // R5: the two strobes never share a cycle
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_tick && sample_tick));

    // R9: an illegal divisor silences the block at the next edge
    p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !div_ok |=> (!bit_tick && !sample_tick && bit_idx == '0));

    // R8: an accepted start yields bit 0 and no strobe
    p_start_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && div_ok) |=> (bit_idx == '0 && !bit_tick && !sample_tick));

    // R6: index never leaves the frame
    p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx < IDX_W'(FRAME_BITS));

    // R1: an expiring counter in a running frame produces a boundary strobe
    p_expire_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == GEN_RUN && st_q.cnt == '0 && div_ok && !start) |=> bit_tick);

    // R7: idle without a start stays quiet
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == GEN_IDLE && !start) |=> !sample_tick);

    // R3: pointer advances in step with the index
    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && bit_idx != '0) |-> (st_q.ptr == PTR_W'(int'(bit_idx) % MOD_W)));
endmodule

// File: tb/baud_mod_gen_tb.sv
`timescale 1ns/1ps
module baud_mod_gen_tb;
    localparam int FRAME_BITS = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] divisor = 16'd13;
    logic [7:0]  mod_pattern = 8'h00;
    logic        start = 1'b0;
    logic        bit_tick;
    logic        sample_tick;
    logic [3:0]  bit_idx;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    baud_mod_gen u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .divisor     (divisor),
        .mod_pattern (mod_pattern),
        .start       (start),
        .bit_tick    (bit_tick),
        .sample_tick (sample_tick),
        .bit_idx     (bit_idx)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // expected outputs after the edge lying t edges past the start edge
    function automatic void expect_at(input int t, input int dv, input logic [7:0] pat,
                                      output int e_tick, output int e_samp, output int e_idx);
        int acc = 0;
        e_tick = 0; e_samp = 0; e_idx = 0;
        for (int j = 0; j < FRAME_BITS; j++) begin
            int len = dv + int'(pat[j % 8]);
            if (t == acc + len / 2) e_samp = 1;
            if (t == acc + len) e_tick = 1;
            if (t >= acc && t < acc + len) e_idx = j;
            acc += len;
        end
    endfunction

    function automatic int frame_total(input int dv, input logic [7:0] pat);
        int acc = 0;
        for (int j = 0; j < FRAME_BITS; j++) acc += dv + int'(pat[j % 8]);
        return acc;
    endfunction

    task automatic pulse_start(input int dv, input logic [7:0] pat);
        divisor = 16'(dv);
        mod_pattern = pat;
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
    endtask

    task automatic watch(input int dv, input logic [7:0] pat, input int ncyc);
        int ticks = 0;
        int total = frame_total(dv, pat);
        for (int t = 0; t < ncyc; t++) begin
            int e_tick, e_samp, e_idx;
            @(negedge clk);
            expect_at(t, dv, pat, e_tick, e_samp, e_idx);
            chk("R1 R2 R3 bit_tick", int'(bit_tick), e_tick);
            chk("R5 sample_tick", int'(sample_tick), e_samp);
            chk("R6 bit_idx", int'(bit_idx), e_idx);
            if (t > total) chk("R7 quiet after frame", int'(bit_tick | sample_tick), 0);
            if (bit_tick) begin
                ticks++;
                if (ticks == FRAME_BITS) chk("R4 cumulative end", t, total);
            end
        end
    endtask

    task automatic watch_idle(input string tag, input int ncyc);
        for (int t = 0; t < ncyc; t++) begin
            @(negedge clk);
            chk(tag, int'(bit_tick), 0);
            chk(tag, int'(sample_tick), 0);
            chk(tag, int'(bit_idx), 0);
        end
    endtask

    task automatic full_frame(input int dv, input logic [7:0] pat);
        pulse_start(dv, pat);
        watch(dv, pat, frame_total(dv, pat) + 6);
    endtask

    initial begin
        void'($urandom(32'd1337));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 reset bit_tick", int'(bit_tick), 0);
        chk("R10 reset sample_tick", int'(sample_tick), 0);
        chk("R10 reset bit_idx", int'(bit_idx), 0);
        rst_n = 1'b1;
        watch_idle("R10 idle after reset", 4);

        // reference case: lengths 14,14,13,14,13,14,14,13; end at 164
        chk("R4 reference total", frame_total(13, 8'h6B), 164);
        full_frame(13, 8'h6B);
        // extremes of the pattern and the smallest legal divisor
        full_frame(3, 8'hFF);
        full_frame(3, 8'h00);
        full_frame(4, 8'h01);
        full_frame(20, 8'h80);
        full_frame(7, 8'hAA);

        // R8: restart mid-frame with a non-uniform pattern
        pulse_start(9, 8'h0F);
        watch(9, 8'h0F, 47);
        full_frame(9, 8'hF0);
        // R8: restart in the cycle that would end the frame
        pulse_start(5, 8'h00);
        watch(5, 8'h00, 59);
        full_frame(6, 8'h03);

        // R9: start with an illegal divisor is ignored
        pulse_start(2, 8'hFF);
        watch_idle("R9 illegal start", 20);
        pulse_start(0, 8'h55);
        watch_idle("R9 zero divisor", 10);
        // R9: running frame abandoned when divisor turns illegal
        pulse_start(10, 8'h33);
        watch(10, 8'h33, 30);
        divisor = 16'd1;
        watch_idle("R9 abandon frame", 25);

        for (int k = 0; k < 10; k++) begin
            int dv = int'($urandom_range(3, 40));
            logic [7:0] pat = 8'($urandom);
            full_frame(dv, pat);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule